// File: doc/BRIEF.md
# Privilege-Split Branch Target Cache

This block predicts the target of taken branches for an instruction fetch unit. It is direct-mapped and virtually tagged: the fetch program counter is split into an index that picks one entry and a tag compared against the stored upper address bits. Storage is divided into two equal partitions, one for kernel-mode fetch addresses and one for user-mode ones. The privilege flag that comes with each fetch or update selects the partition that is read or written.

The split lets the operating system drop stale user-mode predictions on a process switch without losing the kernel's trained entries. A process-switch strobe invalidates the user partition only. A virtual-machine-switch strobe invalidates both partitions. Branch resolution feeds an update port. Resolved taken branches install or refresh an entry. Resolved not-taken branches that hit remove their entry.

Top module: `split_btc`

## Requirements
- R1: With default parameters, a 32-bit program counter uses bits [7:2] as the entry index and bits [31:8] as the stored tag. Each partition holds 64 entries. Two addresses that share an index but differ in any tag bit do not alias.
- R2: A lookup hits only when the entry at the index in the partition named by the fetch privilege flag (1 = kernel, 0 = user) is valid and its tag equals the fetch tag. A hit drives the taken flag high and the stored target on the target output in the same cycle.
- R3: A lookup that misses drives the taken flag low and the target output to zero.
- R4: An update marked taken writes the tag and target into the entry at the update index and sets it valid. The new contents are seen by lookups from the cycle after the clock edge. A lookup in the update cycle still sees the old contents.
- R5: An update marked not-taken invalidates its entry only if that entry is valid and its tag matches. Otherwise it changes nothing.
- R6: An update writes only the partition selected by its privilege flag. The same address looked up with the other privilege flag does not hit on that entry.
- R7: A process-switch strobe invalidates every user entry. Kernel entries keep their contents.
- R8: A virtual-machine-switch strobe invalidates every entry in both partitions.
- R9: A lookup in the same cycle as a strobe that clears its partition returns a miss.
- R10: When an update and a strobe that clears the update's partition arrive in the same cycle, the strobe wins and the entry stays invalid. An update to the kernel partition during a process-switch strobe is written normally.
- R11: Asynchronous active-low reset invalidates every entry in both partitions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_pc_i | input | PC_W | Virtual fetch address being looked up |
| fetch_kern_i | input | 1 | Fetch privilege: 1 kernel, 0 user |
| upd_valid_i | input | 1 | Update from branch resolution is present |
| upd_pc_i | input | PC_W | Virtual address of the resolved branch |
| upd_kern_i | input | 1 | Privilege of the resolved branch: 1 kernel, 0 user |
| upd_taken_i | input | 1 | Resolved direction: 1 taken |
| upd_target_i | input | PC_W | Resolved target address |
| flush_proc_i | input | 1 | Process-switch strobe, clears user partition |
| flush_vm_i | input | 1 | Virtual-machine-switch strobe, clears both partitions |
| pred_taken_o | output | 1 | Lookup hit, predicted taken |
| pred_target_o | output | PC_W | Predicted target, zero on a miss |

## Verification
Lookups are combinational, so the prediction for a fetch address is due in the cycle it is presented. Updates and flush strobes take effect at the next rising edge and show up in lookups from the following cycle. The bench changes inputs on the falling edge and samples outputs one nanosecond later, well before the next rising edge. For each update or strobe it runs one lookup in the cycle the input is applied, which must show the old contents or a flush miss, and then sweeps after the edge, which must show the new contents. The expected values come from a per-partition model of valid bits, tags and targets that applies the update and flush rules at each edge.

// File: rtl/btc_pkg.sv
package btc_pkg;
  typedef enum logic {
    PART_USER = 1'b0,
    PART_KERN = 1'b1
  } part_e;

  localparam int unsigned NUM_PARTS = 2;
endpackage

// File: rtl/btc_bank.sv
module btc_bank #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 6,
  parameter int unsigned OFS_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  logic            rd_en_i,
  input  logic [PC_W-1:0] rd_pc_i,
  output logic            hit_o,
  output logic [PC_W-1:0] tgt_o,
  input  logic            wr_i,
  input  logic [PC_W-1:0] wr_pc_i,
  input  logic            wr_taken_i,
  input  logic [PC_W-1:0] wr_tgt_i
);
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam int unsigned TAG_W = PC_W - IDX_W - OFS_W;

  logic [DEPTH-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [PC_W-1:0]  tgt_q [DEPTH];

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [TAG_W-1:0] rd_tag, wr_tag;
  logic             wr_match, do_set, do_clr;

  assign rd_idx = rd_pc_i[OFS_W +: IDX_W];
  assign rd_tag = rd_pc_i[PC_W-1 -: TAG_W];
  assign wr_idx = wr_pc_i[OFS_W +: IDX_W];
  assign wr_tag = wr_pc_i[PC_W-1 -: TAG_W];

  assign wr_match = valid_q[wr_idx] && (tag_q[wr_idx] == wr_tag);
  assign do_set   = wr_i && wr_taken_i && !flush_i;
  assign do_clr   = wr_i && !wr_taken_i && !flush_i && wr_match;

  // flush beats any same-cycle write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
    end else if (do_set) begin
      valid_q[wr_idx] <= 1'b1;
    end else if (do_clr) begin
      valid_q[wr_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_set) begin
      tag_q[wr_idx] <= wr_tag;
      tgt_q[wr_idx] <= wr_tgt_i;
    end
  end

  assign hit_o = rd_en_i && !flush_i && valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign tgt_o = hit_o ? tgt_q[rd_idx] : '0;

  a_r8_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0));
  a_r4_taken_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_taken_i && !flush_i) |=> valid_q[$past(wr_idx)]);
  a_r5_not_taken_hit_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wr_taken_i && !flush_i && valid_q[wr_idx] && (tag_q[wr_idx] == wr_tag))
      |=> !valid_q[$past(wr_idx)]);
  a_r7_idle_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && !wr_i) |=> $stable(valid_q));
  a_r9_flush_lookup_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !hit_o);
endmodule

// File: rtl/split_btc.sv
module split_btc #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 6,
  parameter int unsigned OFS_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] fetch_pc_i,
  input  logic            fetch_kern_i,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_kern_i,
  input  logic            upd_taken_i,
  input  logic [PC_W-1:0] upd_target_i,
  input  logic            flush_proc_i,
  input  logic            flush_vm_i,
  output logic            pred_taken_o,
  output logic [PC_W-1:0] pred_target_o
);
  import btc_pkg::*;

  logic [NUM_PARTS-1:0] part_hit;
  logic [PC_W-1:0]      part_tgt [NUM_PARTS];
  logic [NUM_PARTS-1:0] part_flush;

  assign part_flush[PART_KERN] = flush_vm_i;
  assign part_flush[PART_USER] = flush_vm_i | flush_proc_i;

  for (genvar p = 0; p < NUM_PARTS; p++) begin : g_part
    localparam logic PART_SEL = (p == int'(PART_KERN));
    btc_bank #(
      .PC_W (PC_W),
      .IDX_W(IDX_W),
      .OFS_W(OFS_W)
    ) i_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .flush_i   (part_flush[p]),
      .rd_en_i   (fetch_kern_i == PART_SEL),
      .rd_pc_i   (fetch_pc_i),
      .hit_o     (part_hit[p]),
      .tgt_o     (part_tgt[p]),
      .wr_i      (upd_valid_i && (upd_kern_i == PART_SEL)),
      .wr_pc_i   (upd_pc_i),
      .wr_taken_i(upd_taken_i),
      .wr_tgt_i  (upd_target_i)
    );
  end

  assign pred_taken_o  = |part_hit;
  assign pred_target_o = part_tgt[PART_KERN] | part_tgt[PART_USER];

  a_r6_one_partition: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(part_hit));
  a_r3_miss_zero_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_taken_o |-> (pred_target_o == '0));
  a_r9_vm_flush_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_vm_i |-> !pred_taken_o);
  a_r9_proc_flush_user_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_proc_i && !fetch_kern_i) |-> !pred_taken_o);
endmodule

// File: tb/test_split_btc.sv
module test_split_btc;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] fetch_pc;
  logic        fetch_kern;
  logic        upd_valid;
  logic [31:0] upd_pc;
  logic        upd_kern;
  logic        upd_taken;
  logic [31:0] upd_target;
  logic        flush_proc;
  logic        flush_vm;
  logic        pred_taken;
  logic [31:0] pred_target;

  always #2.5 clk = ~clk;

  split_btc i_split_btc (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .fetch_pc_i   (fetch_pc),
    .fetch_kern_i (fetch_kern),
    .upd_valid_i  (upd_valid),
    .upd_pc_i     (upd_pc),
    .upd_kern_i   (upd_kern),
    .upd_taken_i  (upd_taken),
    .upd_target_i (upd_target),
    .flush_proc_i (flush_proc),
    .flush_vm_i   (flush_vm),
    .pred_taken_o (pred_taken),
    .pred_target_o(pred_target)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // model: index 1 = kernel, 0 = user
  bit          mv   [2][64];
  logic [23:0] mtag [2][64];
  logic [31:0] mtg  [2][64];

  function automatic logic [31:0] upc(int i);
    return {24'h001234, i[5:0], 2'b00};
  endfunction
  function automatic logic [31:0] kpc(int i);
    return {24'hFFFF80, i[5:0], 2'b00};
  endfunction
  function automatic logic [31:0] utg(int i);
    return 32'h1000_0000 + i * 8;
  endfunction
  function automatic logic [31:0] ktg(int i);
    return 32'h8000_0000 ^ (i << 4);
  endfunction

  task automatic chk(string rq, bit k, logic [31:0] pc, bit force_miss);
    int          p;
    logic [5:0]  idx;
    bit          eh;
    logic [31:0] et;
    p   = k ? 1 : 0;
    idx = pc[7:2];
    fetch_kern = k;
    fetch_pc   = pc;
    #1;
    eh = !force_miss && mv[p][idx] && (mtag[p][idx] == pc[31:8]);
    et = eh ? mtg[p][idx] : 32'h0;
    total++;
    if (pred_taken !== eh || pred_target !== et) begin
      bad++;
      $display("FAIL %s: pc=%h kern=%0b taken=%0b target=%h expected taken=%0b target=%h",
               rq, pc, k, pred_taken, pred_target, eh, et);
    end
  endtask

  // one cycle of update/flush; optional lookup check in that same cycle
  task automatic step(bit uv, bit k, logic [31:0] pc, bit tk, logic [31:0] tg,
                      bit fp, bit fv, bit pre, string prq, bit pk, logic [31:0] ppc, bit pmiss);
    int p;
    bit fl;
    upd_valid  = uv;
    upd_kern   = k;
    upd_pc     = pc;
    upd_taken  = tk;
    upd_target = tg;
    flush_proc = fp;
    flush_vm   = fv;
    if (pre) chk(prq, pk, ppc, pmiss);
    @(posedge clk);
    if (fv) begin
      for (int i = 0; i < 64; i++) begin mv[0][i] = 0; mv[1][i] = 0; end
    end else if (fp) begin
      for (int i = 0; i < 64; i++) mv[0][i] = 0;
    end
    if (uv) begin
      p  = k ? 1 : 0;
      fl = fv || (fp && !k);
      if (!fl) begin
        if (tk) begin
          mv[p][pc[7:2]]   = 1;
          mtag[p][pc[7:2]] = pc[31:8];
          mtg[p][pc[7:2]]  = tg;
        end else if (mv[p][pc[7:2]] && mtag[p][pc[7:2]] == pc[31:8]) begin
          mv[p][pc[7:2]] = 0;
        end
      end
    end
    @(negedge clk);
    upd_valid = 0; flush_proc = 0; flush_vm = 0;
  endtask

  task automatic fill_all();
    for (int i = 0; i < 64; i++) begin
      step(1, 0, upc(i), 1, utg(i), 0, 0, 0, "", 0, 0, 0);
      step(1, 1, kpc(i), 1, ktg(i), 0, 0, 0, "", 0, 0, 0);
    end
  endtask

  task automatic sweep(string rq);
    for (int i = 0; i < 64; i++) begin
      chk(rq, 0, upc(i), 0);
      chk(rq, 1, kpc(i), 0);
    end
  endtask

  initial begin
    #(5 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      mv[0][i] = 0; mv[1][i] = 0;
      mtag[0][i] = '0; mtag[1][i] = '0;
      mtg[0][i] = '0; mtg[1][i] = '0;
    end
    rst_n = 0; fetch_pc = 0; fetch_kern = 0; upd_valid = 0; upd_pc = 0;
    upd_kern = 0; upd_taken = 0; upd_target = 0; flush_proc = 0; flush_vm = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R11 empty after reset
    sweep("R11");

    // R2 install and hit in both partitions
    fill_all();
    sweep("R2");
    for (int i = 0; i < 64; i++) begin
      // R6 other privilege does not see the entry
      chk("R6", 1, upc(i), 0);
      chk("R6", 0, kpc(i), 0);
      // R1 R3 tag mismatch at same index misses
      chk("R1", 0, upc(i) ^ 32'h0100_0000, 0);
      chk("R3", 1, kpc(i) ^ 32'h0000_0100, 0);
    end

    // R4 same-cycle lookup sees old target, next cycle sees new
    step(1, 0, upc(5), 1, 32'hCAFE_0004, 0, 0, 1, "R4", 0, upc(5), 0);
    chk("R4", 0, upc(5), 0);
    // R4 retag at same index replaces old entry
    step(1, 1, kpc(6) ^ 32'h0000_1000, 1, 32'h1234_5678, 0, 0, 0, "", 0, 0, 0);
    chk("R4", 1, kpc(6) ^ 32'h0000_1000, 0);
    chk("R4", 1, kpc(6), 0);

    // R5 not-taken hit clears, not-taken with other tag leaves entry
    step(1, 0, upc(3), 0, 32'h0, 0, 0, 0, "", 0, 0, 0);
    chk("R5", 0, upc(3), 0);
    step(1, 0, upc(4) ^ 32'h0000_0100, 0, 32'h0, 0, 0, 0, "", 0, 0, 0);
    chk("R5", 0, upc(4), 0);
    step(1, 1, kpc(3), 0, 32'h0, 0, 0, 0, "", 0, 0, 0);
    chk("R5", 1, kpc(3), 0);
    chk("R6", 0, upc(3), 0);

    // R7 R9 process flush: user lookup in flush cycle misses
    step(0, 0, 0, 0, 0, 1, 0, 1, "R9", 0, upc(10), 1);
    sweep("R7");
    // R9 kernel lookup unaffected during process flush
    step(0, 0, 0, 0, 0, 1, 0, 1, "R9", 1, kpc(11), 0);

    // R10 user update during process flush dropped, kernel update kept
    step(1, 0, upc(7), 1, 32'hDEAD_0000, 1, 0, 0, "", 0, 0, 0);
    chk("R10", 0, upc(7), 0);
    step(1, 1, kpc(9), 1, 32'hBEEF_0000, 1, 0, 0, "", 0, 0, 0);
    chk("R10", 1, kpc(9), 0);

    // R8 R9 VM flush clears both, lookup in flush cycle misses
    fill_all();
    step(0, 0, 0, 0, 0, 0, 1, 1, "R9", 1, kpc(20), 1);
    sweep("R8");

    // R10 kernel update during VM flush dropped
    step(1, 1, kpc(2), 1, 32'h7777_0000, 0, 1, 0, "", 0, 0, 0);
    chk("R10", 1, kpc(2), 0);

    // R11 reset mid-run clears filled cache
    fill_all();
    #1 rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 64; i++) begin mv[0][i] = 0; mv[1][i] = 0; end
    @(negedge clk);
    sweep("R11");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule